// File: doc/BRIEF.md
# Glitch-Free Selectable Clock Divider Bank

This block turns one fast source clock into three banks of divided clocks, A, B and C, each bank driving four outputs that carry the same waveform. Each bank's divide ratio comes from a small fixed table. A 2-bit per-bank select and one shared rate control index that table. With the rate control low, every ratio in every bank is doubled, so the frequency ratios between the banks stay the same. Every ratio is even, and every output has an exact 50% duty cycle.

The selects and the rate control may change while the block runs. A new ratio is adopted only when a bank's output is about to rise, at the end of a complete low phase. The period in progress therefore always finishes with the ratio it started with. No output period is ever shorter or longer than both the old and the new period. Bank C can also complement its outputs 2 and 3. These outputs still come from flip-flops clocked in the same cycle as the other outputs, so the inversion adds no skew.

Top module: `clock_divider_bank`

## Requirements
- R1: Within a bank, the four outputs are identical in every cycle. The exception is bank C outputs 2 and 3 while inversion is enabled.
- R2: Bank A divides by 4, 6, 8, 12 for select 0, 1, 2, 3 when `full_rate` is 1, and by 8, 12, 16, 24 when it is 0.
- R3: Bank B divides by 4, 6, 8, 10 for select 0, 1, 2, 3 when `full_rate` is 1, and by 8, 12, 16, 20 when it is 0.
- R4: Bank C divides by 2, 4, 6, 8 for select 0, 1, 2, 3 when `full_rate` is 1, and by 4, 8, 12, 16 when it is 0.
- R5: Driving `full_rate` to 0 doubles the ratio of all three banks at once.
- R6: Two cycles after `inv_c` is sampled high, `qc[2]` and `qc[3]` are the complements of `qc[0]` and `qc[1]`. When `inv_c` is low, they equal them.
- R7: A changed select or `full_rate` is adopted only at a rising output edge. Every rising-to-rising period equals either the old ratio or the new ratio.
- R8: Every output is high for exactly half of its period and low for the other half.
- R9: While `rst` is high, all outputs are low and each bank's ratio is loaded from the current inputs. Each bank first rises ratio/2 cycles after the first clock edge with `rst` low, so the first rising edges of all three banks follow this rule together.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Source clock |
| rst | input | 1 | Synchronous active-high reset |
| sel_a | input | 2 | Bank A ratio select |
| sel_b | input | 2 | Bank B ratio select |
| sel_c | input | 2 | Bank C ratio select |
| full_rate | input | 1 | 1 = base ratios, 0 = all ratios doubled |
| inv_c | input | 1 | Complement bank C outputs 2 and 3 |
| qa | output | 4 | Bank A clock outputs |
| qb | output | 4 | Bank B clock outputs |
| qc | output | 4 | Bank C clock outputs |

## Verification
The critical coincidence is a newly registered ratio request that lands in the very cycle a bank's output rises. That cycle decides whether the old or the new ratio governs the next period. Randomly timed segments of 60 to 120 cycles move the change point across every phase of all three banks. Some of these changes toggle `full_rate`, which hits all banks at once. Each measured rising-to-rising period must equal the old or the new table ratio, with its high half exactly equal to half of it. By the end of each segment the last period must equal the new ratio.

// File: rtl/clkdiv_pkg.sv
package clkdiv_pkg;

  localparam int HALF_W  = 5;
  localparam int N_BANK  = 3;
  localparam int N_OUT   = 4;

  localparam int BANK_A = 0;
  localparam int BANK_B = 1;
  localparam int BANK_C = 2;

  // Half-period length in source cycles for one bank and one setting.
  function automatic logic [HALF_W-1:0] bank_half(input int bank,
                                                  input logic [1:0] sel,
                                                  input logic full);
    logic [HALF_W-1:0] base;
    case (bank)
      BANK_A:  base = (sel == 2'd3) ? HALF_W'(6) : HALF_W'(sel) + HALF_W'(2);
      BANK_B:  base = HALF_W'(sel) + HALF_W'(2);
      default: base = HALF_W'(sel) + HALF_W'(1);
    endcase
    return full ? base : (base << 1);
  endfunction

endpackage

// File: rtl/cdb_input_stage.sv
module cdb_input_stage (
  input  logic       clk,
  input  logic [1:0] sel_a_in,
  input  logic [1:0] sel_b_in,
  input  logic [1:0] sel_c_in,
  input  logic       full_in,
  input  logic       inv_in,
  output logic [1:0] sel_a_r,
  output logic [1:0] sel_b_r,
  output logic [1:0] sel_c_r,
  output logic       full_r,
  output logic       inv_r
);
  // Capture every cycle, reset included, so the stage is current at release.
  always_ff @(posedge clk) begin
    sel_a_r <= sel_a_in;
    sel_b_r <= sel_b_in;
    sel_c_r <= sel_c_in;
    full_r  <= full_in;
    inv_r   <= inv_in;
  end
endmodule

// File: rtl/cdb_lane.sv
module cdb_lane
  import clkdiv_pkg::*;
#(
  parameter int               BANK     = 0,
  parameter int               CNT_W    = HALF_W,
  parameter int               OUTS     = N_OUT,
  parameter logic [OUTS-1:0]  INV_MASK = '0
) (
  input  logic            clk,
  input  logic            rst,
  input  logic [1:0]      sel_raw,
  input  logic            full_raw,
  input  logic [1:0]      sel_syn,
  input  logic            full_syn,
  input  logic            inv_en,
  output logic [OUTS-1:0] q
);
  logic [CNT_W-1:0] half_rst, half_new, cur_half, cnt;
  logic             phase_q, phase_d;
  logic             term_evt, rise_evt;

  assign half_rst = CNT_W'(bank_half(BANK, sel_raw, full_raw));
  assign half_new = CNT_W'(bank_half(BANK, sel_syn, full_syn));

  // Named events for the assertions.
  assign term_evt = (cnt == cur_half - CNT_W'(1));
  assign rise_evt = term_evt & ~phase_q;
  assign phase_d  = term_evt ? ~phase_q : phase_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt      <= '0;
      phase_q  <= 1'b0;
      cur_half <= half_rst;
    end else begin
      cnt     <= term_evt ? '0 : cnt + CNT_W'(1);
      phase_q <= phase_d;
      if (rise_evt) cur_half <= half_new;
    end
  end

  // One flop per output; inversion folds into the D input, same edge.
  for (genvar i = 0; i < OUTS; i++) begin : g_out
    always_ff @(posedge clk) begin
      if (rst) q[i] <= 1'b0;
      else     q[i] <= phase_d ^ (INV_MASK[i] & inv_en);
    end
  end

  AST_HOLD_RATIO: assert property (@(posedge clk) disable iff (rst)
    !rise_evt |=> $stable(cur_half)); // R7
  AST_CNT_BOUND: assert property (@(posedge clk) disable iff (rst)
    cnt < cur_half); // R8
  AST_STEADY_PHASE: assert property (@(posedge clk) disable iff (rst)
    !term_evt |=> $stable(phase_q)); // R8
  AST_RESET_LOW: assert property (@(posedge clk)
    rst |=> (q == '0)); // R9
endmodule

// File: rtl/clock_divider_bank.sv
module clock_divider_bank
  import clkdiv_pkg::*;
#(
  parameter int CNT_W = HALF_W,
  parameter int OUTS  = N_OUT
) (
  input  logic            clk,
  input  logic            rst,
  input  logic [1:0]      sel_a,
  input  logic [1:0]      sel_b,
  input  logic [1:0]      sel_c,
  input  logic            full_rate,
  input  logic            inv_c,
  output logic [OUTS-1:0] qa,
  output logic [OUTS-1:0] qb,
  output logic [OUTS-1:0] qc
);
  localparam logic [OUTS-1:0] C_MASK = {{(OUTS-2){1'b1}}, 2'b00};

  logic [1:0]      sel_raw [N_BANK];
  logic [1:0]      sel_syn [N_BANK];
  logic [1:0]      sa_r, sb_r, sc_r;
  logic            full_r, inv_r;
  logic [OUTS-1:0] q_bank  [N_BANK];

  cdb_input_stage i_in (
    .clk(clk), .sel_a_in(sel_a), .sel_b_in(sel_b), .sel_c_in(sel_c),
    .full_in(full_rate), .inv_in(inv_c),
    .sel_a_r(sa_r), .sel_b_r(sb_r), .sel_c_r(sc_r),
    .full_r(full_r), .inv_r(inv_r)
  );

  assign sel_raw[BANK_A] = sel_a;
  assign sel_raw[BANK_B] = sel_b;
  assign sel_raw[BANK_C] = sel_c;
  assign sel_syn[BANK_A] = sa_r;
  assign sel_syn[BANK_B] = sb_r;
  assign sel_syn[BANK_C] = sc_r;

  for (genvar b = 0; b < N_BANK; b++) begin : g_bank
    cdb_lane #(
      .BANK(b), .CNT_W(CNT_W), .OUTS(OUTS),
      .INV_MASK((b == BANK_C) ? C_MASK : '0)
    ) i_lane (
      .clk(clk), .rst(rst),
      .sel_raw(sel_raw[b]), .full_raw(full_rate),
      .sel_syn(sel_syn[b]), .full_syn(full_r),
      .inv_en(inv_r), .q(q_bank[b])
    );
  end

  assign qa = q_bank[BANK_A];
  assign qb = q_bank[BANK_B];
  assign qc = q_bank[BANK_C];

  AST_FANOUT_A: assert property (@(posedge clk) disable iff (rst)
    qa == {OUTS{qa[0]}}); // R1
  AST_INV_PAIR: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && $past(inv_r)) |-> (qc[2] != qc[0] && qc[3] != qc[1])); // R6
endmodule

// File: tb/test_clock_divider_bank.sv
module test_clock_divider_bank;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic [1:0] sel_a = 2'd0, sel_b = 2'd0, sel_c = 2'd0;
  logic       full_rate = 1'b1, inv_c = 1'b0;
  logic [3:0] qa, qb, qc;

  int n_chk = 0, n_fail = 0, cyc = 0, seg_cyc = 0;
  bit done = 1'b0;
  int rise_t [3], fall_t [3], first_rise [3], last_per [3];
  int exp_prev [3], exp_cur [3];
  bit hr [3], hf [3];
  logic prevq [3];

  always #4 clk = ~clk; // 125 MHz

  clock_divider_bank i_clock_divider_bank (
    .clk(clk), .rst(rst), .sel_a(sel_a), .sel_b(sel_b), .sel_c(sel_c),
    .full_rate(full_rate), .inv_c(inv_c), .qa(qa), .qb(qb), .qc(qc)
  );

  // Ratio tables restated from R2..R4, R5.
  function automatic int exp_ratio(int bank, logic [1:0] s, logic f);
    int r;
    case (bank)
      0: case (s) 2'd0: r = 4; 2'd1: r = 6; 2'd2: r = 8;  default: r = 12; endcase
      1: case (s) 2'd0: r = 4; 2'd1: r = 6; 2'd2: r = 8;  default: r = 10; endcase
      default: case (s) 2'd0: r = 2; 2'd1: r = 4; 2'd2: r = 6; default: r = 8; endcase
    endcase
    return f ? r : 2 * r;
  endfunction

  function automatic string tab_tag(int bank);
    return (bank == 0) ? "R2" : (bank == 1) ? "R3" : "R4";
  endfunction

  function automatic logic [1:0] sel_of(int bank);
    return (bank == 0) ? sel_a : (bank == 1) ? sel_b : sel_c;
  endfunction

  task automatic check(bit ok, string tag, int act, int expv);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d (cycle %0d)", tag, act, expv, cyc);
    end
  endtask

  task automatic monitor();
    logic cur;
    for (int b = 0; b < 3; b++) begin
      cur = (b == 0) ? qa[0] : (b == 1) ? qb[0] : qc[0];
      if (cur && !prevq[b]) begin
        if (hr[b] && hf[b] && fall_t[b] > rise_t[b]) begin
          int per, hi;
          per = cyc - rise_t[b];
          hi  = fall_t[b] - rise_t[b];
          check(per == exp_cur[b] || per == exp_prev[b], "R7 period old/new",
                per, exp_cur[b]);
          check(2 * hi == per, "R8 half duty", 2 * hi, per);
          last_per[b] = per;
        end
        rise_t[b] = cyc; hr[b] = 1'b1;
        if (first_rise[b] < 0) first_rise[b] = cyc;
      end
      if (!cur && prevq[b]) begin
        fall_t[b] = cyc; hf[b] = 1'b1;
      end
      prevq[b] = cur;
    end
  endtask

  task automatic step();
    @(posedge clk);
    @(negedge clk);
    cyc++; seg_cyc++;
    if (!rst) begin
      monitor();
      check(qa == {4{qa[0]}} && qb == {4{qb[0]}} && qc[1] == qc[0] && qc[3] == qc[2],
            "R1 bank fanout", {qa, qb, qc}, 0);
      if (seg_cyc >= 2)
        check(qc[2] == (qc[0] ^ inv_c) && qc[3] == (qc[1] ^ inv_c),
              "R6 bank C pair", qc, {qc[1:0] ^ {2{inv_c}}, qc[1:0]});
    end
  endtask

  task automatic do_reset(logic [1:0] sa, logic [1:0] sb, logic [1:0] sc, logic f);
    sel_a = sa; sel_b = sb; sel_c = sc; full_rate = f; inv_c = 1'b0;
    rst = 1'b1;
    for (int i = 0; i < 3; i++) begin
      step();
      check(qa == 4'd0 && qb == 4'd0 && qc == 4'd0, "R9 outputs low in reset",
            {qa, qb, qc}, 0);
    end
    for (int b = 0; b < 3; b++) begin
      hr[b] = 0; hf[b] = 0; prevq[b] = 1'b0; first_rise[b] = -1; last_per[b] = 0;
      exp_cur[b] = exp_ratio(b, sel_of(b), f); exp_prev[b] = exp_cur[b];
    end
    cyc = 0; seg_cyc = 0;
    rst = 1'b0;
    for (int i = 0; i < 60; i++) step();
    for (int b = 0; b < 3; b++) begin
      check(first_rise[b] == exp_cur[b] / 2, "R9 first rise", first_rise[b], exp_cur[b] / 2);
      check(last_per[b] == exp_cur[b], tab_tag(b), last_per[b], exp_cur[b]);
    end
  endtask

  initial begin
    void'($urandom(32'd20240611));
    // Directed corners: shortest and longest ratios from reset.
    do_reset(2'd0, 2'd0, 2'd0, 1'b1);
    do_reset(2'd3, 2'd3, 2'd3, 1'b0);
    do_reset(2'd1, 2'd2, 2'd3, 1'b1);
    for (int s = 0; s < 40; s++) begin
      int len;
      logic [1:0] na, nb, nc;
      logic nf, ni;
      na = 2'($urandom_range(0, 3)); nb = 2'($urandom_range(0, 3));
      nc = 2'($urandom_range(0, 3));
      nf = (s % 5 == 4) ? ~full_rate : 1'($urandom_range(0, 1)); // R5 toggles
      ni = 1'($urandom_range(0, 1));
      if (s == 0) begin na = 2'd3; nb = 2'd3; nc = 2'd0; nf = 1'b0; end
      if (s == 1) begin na = 2'd0; nb = 2'd0; nc = 2'd3; nf = 1'b1; end
      sel_a = na; sel_b = nb; sel_c = nc; full_rate = nf; inv_c = ni;
      for (int b = 0; b < 3; b++) begin
        exp_prev[b] = exp_cur[b];
        exp_cur[b]  = exp_ratio(b, sel_of(b), nf);
      end
      seg_cyc = 0;
      len = 60 + int'($urandom_range(0, 60));
      for (int i = 0; i < len; i++) step();
      for (int b = 0; b < 3; b++)
        check(last_per[b] == exp_cur[b], tab_tag(b), last_per[b], exp_cur[b]);
    end
    // Reset while running, then confirm restart.
    do_reset(2'd2, 2'd1, 2'd1, 1'b0);
    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog actual=%0d expected=%0d", cyc, 0);
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end
endmodule